// File: doc/BRIEF.md
# Repeated-Split Response Checker

This block is a passive monitor that sits on an AHB-style interconnect. It watches either the port of one memory slave or the initiator side of the bus. It looks only at cycles where a transfer completes. At each such completion it records which master the transfer belonged to and whether the slave answered with a split. It raises an error when a master that was just given a split response gets a second split on its next completed access to the same target.

The monitor remembers one outstanding obligation at a time. A split completion makes its master the "watched" master. The next qualified completion by that master settles the obligation:

- If that completion is not split, the watch is released.
- If that completion is split again, an error is reported and the master stays watched.

Completions by other masters never settle the watch. A split given to a different master moves the watch to that master.

A parameter selects where the monitor is placed:

- **Memory side:** every completion counts.
- **Bus side (default):** only completions whose target qualifier shows the monitored memory count. All other completions are ignored.

Each violation produces a one-cycle error pulse. A sticky flag holds the error until reset.

Top module: `repeated_split_chk`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `err_pulse` and `err_sticky` are 0, and no master is watched.
- R2: A qualified completion with `xfer_split`=1 by master M while M is watched drives `err_pulse` high in the cycle after the completing clock edge.
- R3: A qualified completion with `xfer_split`=0 by the watched master ends the watch. A later split completion by that master then raises no error.
- R4: Qualified non-split completions by other masters leave the watch in place. The watched master's next split still raises an error.
- R5: A qualified split completion by a master other than the watched one moves the watch to that master. The formerly watched master's next split raises no error.
- R6: `xfer_split` and `xfer_mst` have no effect in cycles where `xfer_done` is 0.
- R7: In the bus-side variant (MON_SIDE=1), a completion with `xfer_to_mon`=0 is ignored. It neither changes the watch nor raises an error.
- R8: Each violating completion yields exactly one cycle of `err_pulse`. Back-to-back violations yield back-to-back pulses.
- R9: `err_sticky` rises with the first `err_pulse` and stays 1 until reset.
- R10: Master IDs are 4 bits wide, and every value 0 to 15 is a real master. The reset value of the watch register matches none of them, so ID 15 behaves like any other ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| xfer_done | input | 1 | A transfer completes in this cycle |
| xfer_mst | input | 4 | Master ID of the completing transfer |
| xfer_split | input | 1 | The completing transfer's response is a split |
| xfer_to_mon | input | 1 | The completing transfer targets the monitored memory (bus-side variant only) |
| err_pulse | output | 1 | One-cycle pulse per repeated split |
| err_sticky | output | 1 | Latched error, cleared only by reset |

## Verification
The hardest situation to reach is a violation separated from its triggering split by traffic that must not disturb the watch. Examples are completions by other masters, completions to other targets, and cycles where a split response appears with no completion strobe. The directed stimulus builds each of these chains explicitly, checking the watched master's second split both when it must fire and after the watch has been moved or released.

A long random phase then draws from only three master IDs, with a high split probability and a randomly toggled target qualifier. This makes same-master repeats and watch hand-overs frequent. A behavioural model in the bench tracks the watched master as an integer and is compared against both outputs on every cycle.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the completion record used by the
// repeated-split checker. Assumes master IDs fit in RSC_MST_W bits.
package rsc_pkg;
    parameter int unsigned RSC_MST_W  = 4;
    // watch register is one bit wider so its reset value matches no ID
    localparam int unsigned RSC_OWN_W = RSC_MST_W + 1;
    localparam logic [RSC_OWN_W-1:0] RSC_NOBODY = RSC_OWN_W'(1) << RSC_MST_W;

    typedef struct packed {
        logic                 vld;   // qualified completion this cycle
        logic                 split; // its response was a split
        logic [RSC_MST_W-1:0] mst;   // master that issued it
    } rsc_cmpl_t;
endpackage

// File: rtl/rsc_qualify.sv
`timescale 1ns/1ps
// Module: rsc_qualify
// Turns raw completion signals into a qualified completion record.
// MON_SIDE=0 (memory side): every completion counts.
// MON_SIDE=1 (bus side): only completions aimed at the monitored memory.
// Assumes xfer_split/xfer_mst are meaningful only while xfer_done is 1.
module rsc_qualify
    import rsc_pkg::*;
#(
    parameter int unsigned MON_SIDE = 1
) (
    input  logic                 xfer_done,
    input  logic [RSC_MST_W-1:0] xfer_mst,
    input  logic                 xfer_split,
    input  logic                 xfer_to_mon,
    output rsc_cmpl_t            cmpl
);
    logic take;

    // choose the qualifier according to the placement variant
    generate
        if (MON_SIDE == 0) begin : g_mem_side
            assign take = xfer_done;
        end else begin : g_bus_side
            assign take = xfer_done & xfer_to_mon;
        end
    endgenerate

    // split is forced false whenever no qualified completion occurs
    always_comb begin
        cmpl.vld   = take;
        cmpl.split = take & xfer_split;
        cmpl.mst   = xfer_mst;
    end
endmodule

// File: rtl/rsc_track.sv
`timescale 1ns/1ps
// Module: rsc_track
// Holds the single watched master (the one most recently given a split)
// and flags a completion that repeats the split to that master.
// Assumes one qualified completion per cycle at most.
module rsc_track
    import rsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rsc_cmpl_t cmpl,
    output logic      repeat_hit,
    output logic      watch_vld
);
    logic [RSC_OWN_W-1:0] owner_q;
    logic                 pend_q;
    logic                 same_mst;

    // does the current completion belong to the watched master
    assign same_mst = (owner_q == {1'b0, cmpl.mst});

    // violation: watched master is split again
    assign repeat_hit = cmpl.vld & cmpl.split & pend_q & same_mst;
    assign watch_vld  = pend_q;

    // update the watch on each qualified completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= RSC_NOBODY;
            pend_q  <= 1'b0;
        end else if (cmpl.vld) begin
            if (cmpl.split) begin
                owner_q <= {1'b0, cmpl.mst};
                pend_q  <= 1'b1;
            end else if (pend_q && same_mst) begin
                owner_q <= RSC_NOBODY;
                pend_q  <= 1'b0;
            end
        end
    end

    // R3: an idle watch always holds the no-master value
    assert_idle_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |-> (owner_q == RSC_NOBODY));

    // R10: an active watch always names a real 4-bit master
    assert_owner_real_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (owner_q[RSC_MST_W] == 1'b0));
endmodule

// File: rtl/rsc_report.sv
`timescale 1ns/1ps
// Module: rsc_report
// Registers the violation strobe into a one-cycle pulse and a sticky flag.
// Assumes the strobe comes from combinational tracking of the same cycle.
module rsc_report (
    input  logic clk,
    input  logic rst_n,
    input  logic repeat_hit,
    output logic err_pulse,
    output logic err_sticky
);
    // pulse follows each violation; sticky latches until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse  <= repeat_hit;
            err_sticky <= err_sticky | repeat_hit;
        end
    end

    // R9: once set the sticky flag never drops without reset
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R8: a pulse is always reflected in the sticky flag
    assert_pulse_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);
endmodule

// File: rtl/repeated_split_chk.sv
`timescale 1ns/1ps
// Module: repeated_split_chk (top)
// Passive monitor: reports a split response given to a master whose
// previous qualified completion was also split. MON_SIDE picks memory-side
// (0) or bus-side (1) placement. Assumes inputs are synchronous to clk.
module repeated_split_chk
    import rsc_pkg::*;
#(
    parameter int unsigned MON_SIDE = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_done,
    input  logic [RSC_MST_W-1:0] xfer_mst,
    input  logic                 xfer_split,
    input  logic                 xfer_to_mon,
    output logic                 err_pulse,
    output logic                 err_sticky
);
    rsc_cmpl_t cmpl;
    logic      repeat_hit;
    logic      watch_vld;

    rsc_qualify #(.MON_SIDE(MON_SIDE)) u_qualify (
        .xfer_done   (xfer_done),
        .xfer_mst    (xfer_mst),
        .xfer_split  (xfer_split),
        .xfer_to_mon (xfer_to_mon),
        .cmpl        (cmpl)
    );

    rsc_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmpl       (cmpl),
        .repeat_hit (repeat_hit),
        .watch_vld  (watch_vld)
    );

    rsc_report u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .repeat_hit (repeat_hit),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky)
    );

    // R2: a pulse only follows a completion answered with a split
    assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(xfer_done && xfer_split));

    // R6: a cycle without completion never produces a pulse
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |=> !err_pulse);

    // R2: a violation needs an active watch
    assert_hit_needs_watch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_hit |-> watch_vld);

    // R7: completions to other targets are ignored in the bus-side variant
    generate
        if (MON_SIDE != 0) begin : g_tgt_chk
            assert_other_tgt_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (xfer_done && !xfer_to_mon) |=> !err_pulse);
        end
    endgenerate
endmodule

// File: tb/repeated_split_chk_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared after every clock edge.
module repeated_split_chk_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_done = 1'b0;
    logic [3:0] xfer_mst = 4'd0;
    logic       xfer_split = 1'b0;
    logic       xfer_to_mon = 1'b0;
    logic       err_pulse;
    logic       err_sticky;

    int vectors = 0;
    int misses  = 0;
    int owner   = -1;     // watched master, -1 = none
    bit exp_pulse  = 1'b0;
    bit exp_sticky = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    repeated_split_chk #(.MON_SIDE(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .xfer_mst(xfer_mst),
        .xfer_split(xfer_split), .xfer_to_mon(xfer_to_mon),
        .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    // one clock: drive, advance model, compare just after the edge
    task automatic step(input bit rst, input bit done, input int id,
                        input bit spl, input bit tgt, input string req);
        bit q;
        rst_n = !rst; xfer_done = done; xfer_mst = 4'(id);
        xfer_split = spl; xfer_to_mon = tgt;
        @(posedge clk);
        #1;
        if (rst) begin
            owner = -1; exp_pulse = 0; exp_sticky = 0;
        end else begin
            q = done && tgt;
            exp_pulse = q && spl && (owner == id);
            exp_sticky = exp_sticky || exp_pulse;
            if (q) begin
                if (spl) owner = id;
                else if (owner == id) owner = -1;
            end
        end
        vectors++;
        if (err_pulse !== exp_pulse || err_sticky !== exp_sticky) begin
            misses++;
            $display("FAIL %s: pulse/sticky = %b%b expected %b%b at %0t",
                     req, err_pulse, err_sticky, exp_pulse, exp_sticky, $time);
        end
    endtask

    task automatic cmp(input int id, input bit spl, input string req);
        step(0, 1, id, spl, 1, req);
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #(4 * 200000);
        misses++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1 reset state, with stimulus present during reset
        step(1, 1, 3, 1, 1, "R1"); step(1, 1, 3, 1, 1, "R1");
        idle("R1");
        cmp(3, 1, "R1"); // first split after reset: no watch yet
        // R2 / R8: repeated splits to master 3, back-to-back pulses
        cmp(3, 1, "R2"); cmp(3, 1, "R8");
        idle("R8");
        // R9: sticky holds over quiet cycles
        for (int i = 0; i < 4; i++) idle("R9");
        step(1, 0, 0, 0, 0, "R9"); idle("R1");
        // R4: another master's ordinary traffic keeps the watch
        cmp(5, 1, "R4"); cmp(6, 0, "R4"); cmp(2, 0, "R4"); cmp(5, 1, "R4");
        step(1, 0, 0, 0, 0, "R1");
        // R3: clean completion releases the watch
        cmp(5, 1, "R3"); cmp(5, 0, "R3"); cmp(5, 1, "R3"); idle("R3");
        step(1, 0, 0, 0, 0, "R1");
        // R5: split to another master moves the watch
        cmp(1, 1, "R5"); cmp(2, 1, "R5"); cmp(1, 1, "R5"); idle("R5");
        cmp(1, 1, "R5"); idle("R5");
        step(1, 0, 0, 0, 0, "R1");
        // R6: split without completion is ignored
        cmp(4, 1, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 4, 1, 1, "R6");
        step(0, 0, 4, 0, 1, "R6");
        cmp(4, 1, "R6"); idle("R6");
        step(1, 0, 0, 0, 0, "R1");
        // R7: completions to other targets do not count
        cmp(7, 1, "R7"); step(0, 1, 7, 1, 0, "R7"); step(0, 1, 7, 0, 0, "R7");
        idle("R7"); cmp(7, 1, "R7"); idle("R7");
        step(1, 0, 0, 0, 0, "R1");
        // R10: ID 15 and ID 0 are real masters
        cmp(15, 1, "R10"); cmp(15, 1, "R10"); cmp(0, 1, "R10"); cmp(0, 1, "R10");
        idle("R10");
        // random phase on three masters
        step(1, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 499) step(1, 0, 0, 0, 0, "R1");
            else step(0, ($urandom % 4) != 0, $urandom % 3, ($urandom % 3) != 0,
                      ($urandom % 5) != 0, "R2");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule